// File: doc/BRIEF.md
# Bubble-Collapsing Stall Pipeline

This block moves data words from a producer to a consumer through five register stages. Each stage carries its own valid flag. When the consumer is ready, all stages shift forward together, and a word appears at the output five clock edges after it is taken in. When the consumer raises its full input, the output word is held. The stages behind it do not freeze: any empty stage pulls in the word from the stage before it. Valid words therefore pack up against the output while the stall lasts. The producer is told to hold only after all five stages are occupied.

The hold signal to the producer is registered, so it never depends combinationally on the producer's valid input. A small controller tracks it with three named states. `ST_FLOW` means the consumer accepted on the last edge. `ST_PACK` means the consumer was full but at least one slot stayed empty. `ST_BLOCK` means the consumer was full and every stage was occupied after the edge. From any state, the controller goes to `ST_FLOW` when full is low, to `ST_BLOCK` when full is high and the next stage flags are all set, and to `ST_PACK` otherwise. Reset enters `ST_FLOW`. The hold output is high only in `ST_BLOCK`.

Top module: `bubble_collapse_pipe`

## Requirements
- R1: A synchronous active-high reset clears all five stage valid flags and enters `ST_FLOW`, so `dst_valid` and `src_hold` read 0 while reset is held and right after it.
- R2: With `dst_full` low, a word captured on an edge is visible on `dst_data` with `dst_valid` high exactly 5 edges later, and words offered on consecutive cycles leave on consecutive cycles.
- R3: While `dst_full` is high and `dst_valid` is high, `dst_valid` and `dst_data` keep the same values on the next cycle.
- R4: While `dst_full` is high, an empty stage loads the word from the stage before it. After a stall, words that entered with gaps between them leave on consecutive cycles once `dst_full` falls.
- R5: `src_hold` is high in a cycle exactly when, at the previous edge, `dst_full` was high and all five stages were occupied after that edge.
- R6: A word is captured when `src_valid` is high, `src_hold` is low, and the pipeline is not both full in all five stages and stalled by `dst_full`. A word offered under any other condition is dropped.
- R7: The words leaving the pipeline are exactly the captured words, in capture order, with none duplicated or lost.
- R8: The output stage releases its word only on an edge where `dst_full` is low. A word counts as delivered when `dst_valid` is high and `dst_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Producer offers a word |
| src_data | input | DATA_W | Producer word |
| src_hold | output | 1 | Registered request for the producer to hold its word |
| dst_valid | output | 1 | Output stage holds a valid word |
| dst_data | output | DATA_W | Output word |
| dst_full | input | 1 | Consumer cannot take a word this cycle |

## Verification
The main function is driven first with an unbroken stream and no stall, which exposes any latency or throughput error. A stall then lands on a completely full stream, which separates correct dropping at the edge from silent loss. Sparse words with gaps between them are sent under a long stall; if the stages froze instead of collapsing, these words would leave with the gaps still in place. A producer that ignores the hold signal shows that refused words never reach the output, and a reset taken with stalled words inside shows that nothing survives it.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

    // Hold-tracking states of the flow controller.
    typedef enum logic [1:0] {
        ST_FLOW  = 2'd0,
        ST_PACK  = 2'd1,
        ST_BLOCK = 2'd2
    } flow_state_e;

endpackage

// File: rtl/bcp_stage.sv
module bcp_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              prev_vld,
    input  logic [DATA_W-1:0] prev_dat,
    output logic              vld_q,
    output logic [DATA_W-1:0] dat_q
);

    // Valid flag: cleared by reset, refreshed whenever the slot loads.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else if (load_en) begin
            vld_q <= prev_vld;
        end
    end

    // Payload carries no reset; it is qualified by vld_q.
    always_ff @(posedge clk) begin
        if (load_en) begin
            dat_q <= prev_dat;
        end
    end

endmodule

// File: rtl/bcp_flow_ctrl.sv
module bcp_flow_ctrl
    import bcp_pkg::*;
#(
    parameter int NUM_STAGES = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_STAGES-1:0] stage_vld,
    input  logic                  dst_full,
    input  logic                  src_valid,
    output logic [NUM_STAGES-1:0] load_en,
    output logic                  take_in,
    output logic                  src_hold
);

    localparam int LAST = NUM_STAGES - 1;

    logic [NUM_STAGES-1:0] ready;
    logic [NUM_STAGES-1:0] vld_next;
    logic                  offer;
    flow_state_e           state_q;
    flow_state_e           state_d;

    // A slot may load when it is empty or when its successor moves.
    always_comb begin
        ready[LAST] = ~stage_vld[LAST] | ~dst_full;
        for (int i = LAST - 1; i >= 0; i--) begin
            ready[i] = ~stage_vld[i] | ready[i+1];
        end
    end

    assign load_en = ready;
    assign offer   = src_valid & ~src_hold;
    assign take_in = offer & ready[0] & ~rst;

    // Occupancy the stages will have after the coming edge.
    always_comb begin
        vld_next[0] = ready[0] ? offer : stage_vld[0];
        for (int i = 1; i < NUM_STAGES; i++) begin
            vld_next[i] = ready[i] ? stage_vld[i-1] : stage_vld[i];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW, ST_PACK, ST_BLOCK: begin
                if (!dst_full) begin
                    state_d = ST_FLOW;
                end else if (&vld_next) begin
                    state_d = ST_BLOCK;
                end else begin
                    state_d = ST_PACK;
                end
            end
            default: state_d = ST_FLOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_BLOCK: src_hold = 1'b1;
            ST_FLOW,
            ST_PACK:  src_hold = 1'b0;
            default:  src_hold = 1'b0;
        endcase
    end

    // R4
    generate
        for (genvar g = 1; g < NUM_STAGES; g++) begin : g_fill
            bubble_fill_chk: assert property (@(posedge clk) disable iff (rst)
                (dst_full && !stage_vld[g] && stage_vld[g-1]) |=> stage_vld[g]);
        end
    endgenerate

    // R8
    last_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dst_full && stage_vld[LAST]) |=> stage_vld[LAST]);

    // R5
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        !dst_full |=> !src_hold);

    // R5
    hold_full_chk: assert property (@(posedge clk) disable iff (rst)
        src_hold |-> ((&stage_vld) && $past(dst_full)));

endmodule

// File: rtl/bubble_collapse_pipe.sv
module bubble_collapse_pipe
    import bcp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_hold,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data,
    input  logic              dst_full
);

    localparam int LAST = NUM_STAGES - 1;

    logic [NUM_STAGES-1:0] stg_vld;
    logic [NUM_STAGES-1:0] stg_load;
    logic [DATA_W-1:0]     stg_dat [NUM_STAGES];
    logic                  take_in;
    logic                  offer_vld;

    assign offer_vld = src_valid & ~src_hold;

    bcp_flow_ctrl #(
        .NUM_STAGES (NUM_STAGES)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .stage_vld (stg_vld),
        .dst_full  (dst_full),
        .src_valid (src_valid),
        .load_en   (stg_load),
        .take_in   (take_in),
        .src_hold  (src_hold)
    );

    generate
        for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                bcp_stage #(
                    .DATA_W (DATA_W)
                ) stage_i (
                    .clk      (clk),
                    .rst      (rst),
                    .load_en  (stg_load[g]),
                    .prev_vld (offer_vld),
                    .prev_dat (src_data),
                    .vld_q    (stg_vld[g]),
                    .dat_q    (stg_dat[g])
                );
            end else begin : g_body
                bcp_stage #(
                    .DATA_W (DATA_W)
                ) stage_i (
                    .clk      (clk),
                    .rst      (rst),
                    .load_en  (stg_load[g]),
                    .prev_vld (stg_vld[g-1]),
                    .prev_dat (stg_dat[g-1]),
                    .vld_q    (stg_vld[g]),
                    .dat_q    (stg_dat[g])
                );
            end
        end
    endgenerate

    assign dst_valid = stg_vld[LAST];
    assign dst_data  = stg_dat[LAST];

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dst_full && dst_valid) |=> (dst_valid && $stable(dst_data)));

    // R7
    word_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(stg_vld) == $past($countones(stg_vld))
            + int'($past(take_in)) - int'($past(dst_valid && !dst_full)));

endmodule

// File: tb/bubble_collapse_pipe_tb_top.sv
`timescale 1ns/1ps
module bubble_collapse_pipe_tb_top;

    localparam int DW = 8;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
        logic          full;
    } vec_t;

    localparam vec_t VECS [24] = '{
        '{1'b1, 8'h01, 1'b0}, '{1'b1, 8'h02, 1'b0}, '{1'b1, 8'h03, 1'b0},
        '{1'b1, 8'h04, 1'b0}, '{1'b1, 8'h05, 1'b0}, '{1'b1, 8'h06, 1'b0},
        '{1'b1, 8'h07, 1'b0}, '{1'b1, 8'h08, 1'b1}, '{1'b1, 8'h09, 1'b1},
        '{1'b0, 8'h00, 1'b0}, '{1'b1, 8'h0A, 1'b0}, '{1'b0, 8'h00, 1'b1},
        '{1'b1, 8'h0B, 1'b1}, '{1'b0, 8'h00, 1'b1}, '{1'b1, 8'h0C, 1'b1},
        '{1'b1, 8'h0D, 1'b0}, '{1'b0, 8'h00, 1'b0}, '{1'b1, 8'h0E, 1'b1},
        '{1'b1, 8'h0F, 1'b1}, '{1'b1, 8'h10, 1'b1}, '{1'b0, 8'h00, 1'b0},
        '{1'b0, 8'h00, 1'b0}, '{1'b1, 8'h11, 1'b0}, '{1'b0, 8'h00, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          src_valid;
    logic [DW-1:0] src_data;
    logic          src_hold;
    logic          dst_valid;
    logic [DW-1:0] dst_data;
    logic          dst_full;

    int            n_checks = 0;
    int            n_err    = 0;
    logic [DW-1:0] sb_q [$];
    logic          exp_hold;
    logic          held_flag;
    logic [DW-1:0] held_dat;

    always #4 clk = ~clk;

    bubble_collapse_pipe #(.DATA_W(DW), .NUM_STAGES(5)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_hold  (src_hold),
        .dst_valid (dst_valid),
        .dst_data  (dst_data),
        .dst_full  (dst_full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // One cycle: drive at the falling edge, then score the registered outputs.
    task automatic step(input logic v, input logic [DW-1:0] d, input logic f);
        int  occ;
        bit  acc;
        @(negedge clk);
        src_valid = v;
        src_data  = d;
        dst_full  = f;
        occ = sb_q.size();
        chk(src_hold == exp_hold, "R5 src_hold", int'(src_hold), int'(exp_hold));
        if (held_flag) begin
            chk(dst_valid && dst_data == held_dat, "R3 stalled output held",
                int'(dst_data), int'(held_dat));
        end
        if (dst_valid && !f) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7 unexpected word", int'(dst_data), 0);
            end else begin
                chk(dst_data == sb_q[0], "R7/R8 delivered word", int'(dst_data), int'(sb_q[0]));
                void'(sb_q.pop_front());
            end
        end
        held_flag = dst_valid && f;
        held_dat  = dst_data;
        acc = v && !exp_hold && !(f && occ == 5);   // R6 capture rule
        if (acc) sb_q.push_back(d);
        exp_hold = f && (sb_q.size() == 5);
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        src_valid = 1'b0;
        src_data  = '0;
        dst_full  = 1'b0;
        repeat (3) @(negedge clk);
        chk(dst_valid == 1'b0, "R1 dst_valid in reset", int'(dst_valid), 0);
        chk(src_hold == 1'b0, "R1 src_hold in reset", int'(src_hold), 0);
        rst = 1'b0;
        sb_q.delete();
        exp_hold  = 1'b0;
        held_flag = 1'b0;
        held_dat  = '0;
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0);
        chk(sb_q.size() == 0, "R7 all words delivered", sb_q.size(), 0);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        do_reset();
        step(1'b0, 8'h00, 1'b0);
        chk(dst_valid == 1'b0, "R1 dst_valid after reset", int'(dst_valid), 0);

        // Vector table: streams, stall onto a full stream, sparse stalls.
        for (int i = 0; i < 24; i++) step(VECS[i].vld, VECS[i].dat, VECS[i].full);
        drain(8);

        // R2: latency of five edges with no stall.
        step(1'b1, 8'h5A, 1'b0);
        for (int k = 1; k <= 4; k++) begin
            step(1'b0, 8'h00, 1'b0);
            chk(dst_valid == 1'b0, "R2 not yet out", int'(dst_valid), 0);
        end
        step(1'b0, 8'h00, 1'b0);
        chk(dst_valid && dst_data == 8'h5A, "R2 out after 5 edges", int'(dst_data), 8'h5A);
        drain(3);

        // R4: sparse words under a long stall collapse together.
        step(1'b1, 8'hA1, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'hA2, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'hA3, 1'b1);
        for (int k = 0; k < 8; k++) step(1'b0, 8'h00, 1'b1);
        chk(dst_valid && dst_data == 8'hA1, "R4 head at output", int'(dst_data), 8'hA1);
        chk(src_hold == 1'b0, "R5 no hold with free slots", int'(src_hold), 0);
        step(1'b0, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b0);
        chk(dst_valid && dst_data == 8'hA2, "R4 packed second word", int'(dst_data), 8'hA2);
        step(1'b0, 8'h00, 1'b0);
        chk(dst_valid && dst_data == 8'hA3, "R4 packed third word", int'(dst_data), 8'hA3);
        drain(6);

        // R5/R6: fill all five under stall; producer then ignores the hold.
        for (int k = 0; k < 5; k++) step(1'b1, 8'h10 + 8'(k), 1'b1);
        step(1'b1, 8'hEE, 1'b1);
        chk(src_hold == 1'b1, "R5 hold when all full", int'(src_hold), 1);
        step(1'b1, 8'hEF, 1'b0);
        chk(src_hold == 1'b1, "R6 hold still registered", int'(src_hold), 1);
        step(1'b0, 8'h00, 1'b0);
        chk(src_hold == 1'b0, "R5 hold released", int'(src_hold), 0);
        drain(8);

        // R1: reset taken with stalled words inside.
        step(1'b1, 8'hC1, 1'b1);
        step(1'b1, 8'hC2, 1'b1);
        step(1'b1, 8'hC3, 1'b1);
        do_reset();
        step(1'b0, 8'h00, 1'b0);
        chk(dst_valid == 1'b0, "R1 pipeline emptied", int'(dst_valid), 0);
        drain(7);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule